// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single requests from a CPU-side port into external memory cycles on one shared 16-bit address/data bus. A request carries an address, write data, two byte enables, a read/write flag and a flag that selects an 8-bit bus. When a request is accepted, the block runs a fixed four-state bus cycle. The four states are address, setup, strobe and hold. In the address state it drives the address on the shared lines. In the setup state it either floats the lines or drives data. In the strobe state it pulses the read or write strobe. In the hold state the cycle ends, and the block reports completion with read data.

One latch pin serves two roles. A static configuration input chooses between them. In the first role it is an active-high pulse that marks the address state. In the second role it is an active-low level that is held from the address state to the end of the strobe state. A second static input picks how the single write pin behaves. It can act as a plain write strobe for every write. Or it can act as a low-byte write strobe, which stays high for a write that touches only the upper byte on the 16-bit bus.

On the 8-bit bus, a 16-bit request becomes two byte cycles, low byte first, and completion is signalled once. The block takes a new request in the hold state of the last byte cycle, so bus cycles can follow each other with no gap.

Top module: `ebc_top`

## Requirements
- R1: After reset, and whenever the block is idle, the outputs are: ad_oe=0, rd_n=1, wr_n=1, rsp_done=0 and req_ready=1. lat_pin is at its idle level: 0 when cfg_latch_mode=0, and 1 when cfg_latch_mode=1.
- R2: Each byte or word cycle lasts exactly four clocks, in the order address, setup, strobe, hold. In the address state, ad_oe=1 and ad_out carries all 16 bits of the cycle address.
- R3: When cfg_latch_mode=0, lat_pin is high in the address state only.
- R4: When cfg_latch_mode=1, lat_pin is low in the address, setup and strobe states. It is high in the hold state and when idle.
- R5: In a read cycle, ad_oe is 0 from the setup state onward, and rd_n is low only in the strobe state. ad_in is captured at the clock edge that ends the strobe state. It appears on rsp_rdata while rsp_done is high in the hold state.
- R6: In a write cycle, the write data is driven with ad_oe=1 in the setup, strobe and hold states. wr_n is low, when enabled, in the strobe state only. ad_oe therefore stays high for one state after wr_n rises.
- R7: When cfg_wr_plain=1, wr_n pulses in every write cycle, whatever the byte enables.
- R8: When cfg_wr_plain=0 and req_narrow=0, wr_n pulses only if req_be[0]=1. A write with req_be=2'b10 drives its data but leaves wr_n high.
- R9: When cfg_wr_plain=0 and req_narrow=1, wr_n pulses in every write byte cycle.
- R10: When req_narrow=1 and req_be=2'b11, the request runs two byte cycles. The first is at req_addr with bits 7:0, the second at req_addr+1 with bits 15:8. rsp_done pulses only in the hold state of the second cycle. For a read, rsp_rdata carries the first byte in bits 7:0 and the second in bits 15:8.
- R11: When req_narrow=1, a single byte cycle runs for req_be=2'b10 at req_addr+1 with bits 15:8, and for req_be=2'b01 at req_addr with bits 7:0. The byte is driven on both lanes of ad_out and read from ad_in[7:0]. Lanes that were not read return 0.
- R12: req_ready is high only when idle or in the hold state of the last byte cycle. A request accepted in that hold state starts its address state on the very next clock.
- R13: rd_n and wr_n are never low together, and rd_n is low only in read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one state time |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_narrow | input | 1 | 1 selects the 8-bit bus for this request |
| req_be | input | 2 | Byte enables, bit 0 for the low byte |
| req_addr | input | 16 | Request address (even for word requests) |
| req_wdata | input | 16 | Write data |
| cfg_wr_plain | input | 1 | 1: plain write strobe; 0: low-byte write strobe |
| cfg_latch_mode | input | 1 | 0: active-high address latch pulse; 1: active-low address-valid level |
| req_ready | output | 1 | A request is taken on this clock if req_valid is high |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ad_in | input | 16 | Shared bus lines as seen from the pads |
| ad_out | output | 16 | Value driven on the shared bus lines |
| ad_oe | output | 1 | Output enable of the shared bus lines |
| lat_pin | output | 1 | Address latch strobe or address-valid level |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write or low-byte write strobe |

## Verification
A wrong phase register shows at the pins within one clock. It would lengthen or shorten the four-state pattern, move the latch edge, or shift the read or write pulse out of the strobe state. A wrong beat flag in a split access would show on the next address state as the wrong address, or as a completion pulse after the first byte. A lost byte lane shows only when rsp_done is seen, as a zero or misplaced byte in rsp_rdata. For that reason, each read cycle's captured value is compared in its hold state.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    // Phase of one byte or word cycle on the shared bus
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } ebc_phase_e;

    // Number of byte lanes on the shared lines
    localparam int unsigned EBC_LANES = 2;

endpackage

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_narrow,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              load_o,
    output logic              done_o,
    output ebc_phase_e        phase_o,
    output logic              beat_write_o,
    output logic              beat_narrow_o,
    output logic              beat_hi_o,
    output logic              beat_lowbe_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [DATA_W-1:0] beat_wdata_o
);

    localparam int unsigned LANE_W = DATA_W / EBC_LANES;

    typedef struct packed {
        ebc_phase_e        phase;
        logic              write;
        logic              narrow;
        logic              hi;      // current byte cycle carries the upper byte
        logic              split;   // word request on the 8-bit bus
        logic              lowbe;   // low byte enabled in the request
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t s_d, s_q;
    logic last_w;
    logic accept_w;
    logic [LANE_W-1:0] lane_w;

    // A split request still owes its upper byte while hi is clear
    assign last_w    = !(s_q.split && !s_q.hi);
    assign req_ready = (s_q.phase == PH_IDLE) || ((s_q.phase == PH_HOLD) && last_w);
    assign accept_w  = req_valid && req_ready;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE:   s_d.phase = PH_IDLE;
            PH_ADDR:   s_d.phase = PH_SETUP;
            PH_SETUP:  s_d.phase = PH_STROBE;
            PH_STROBE: s_d.phase = PH_HOLD;
            PH_HOLD: begin
                if (!last_w) begin
                    s_d.phase = PH_ADDR;
                    s_d.hi    = 1'b1;
                end else begin
                    s_d.phase = PH_IDLE;
                end
            end
            default:   s_d.phase = PH_IDLE;
        endcase
        if (accept_w) begin
            s_d.phase  = PH_ADDR;
            s_d.write  = req_write;
            s_d.narrow = req_narrow;
            s_d.hi     = req_narrow && (req_be == 2'b10);
            s_d.split  = req_narrow && (req_be == 2'b11);
            s_d.lowbe  = req_be[0];
            s_d.addr   = req_addr;
            s_d.wdata  = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lane_w = s_q.hi ? s_q.wdata[DATA_W-1:LANE_W] : s_q.wdata[LANE_W-1:0];

    assign load_o        = accept_w;
    assign done_o        = (s_q.phase == PH_HOLD) && last_w;
    assign phase_o       = s_q.phase;
    assign beat_write_o  = s_q.write;
    assign beat_narrow_o = s_q.narrow;
    assign beat_hi_o     = s_q.hi;
    assign beat_lowbe_o  = s_q.lowbe;
    assign beat_addr_o   = s_q.addr + ADDR_W'(s_q.hi);
    assign beat_wdata_o  = s_q.narrow ? {EBC_LANES{lane_w}} : s_q.wdata;

endmodule

// File: rtl/ebc_strobe.sv
module ebc_strobe
    import ebc_pkg::*;
(
    input  ebc_phase_e phase_i,
    input  logic       write_i,
    input  logic       narrow_i,
    input  logic       lowbe_i,
    input  logic       cfg_wr_plain,
    input  logic       cfg_latch_mode,
    output logic       lat_pin,
    output logic       rd_n,
    output logic       wr_n
);

    logic wr_en_w;
    logic ale_w;
    logic adv_n_w;

    always_comb begin
        // Low-byte style on the wide bus skips writes of the upper byte only
        wr_en_w = cfg_wr_plain || narrow_i || lowbe_i;
        ale_w   = (phase_i == PH_ADDR);
        adv_n_w = !((phase_i == PH_ADDR) || (phase_i == PH_SETUP) || (phase_i == PH_STROBE));
        rd_n    = !((phase_i == PH_STROBE) && !write_i);
        wr_n    = !((phase_i == PH_STROBE) && write_i && wr_en_w);
        lat_pin = cfg_latch_mode ? adv_n_w : ale_w;
    end

endmodule

// File: rtl/ebc_addata.sv
module ebc_addata
    import ebc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  ebc_phase_e        phase_i,
    input  logic              write_i,
    input  logic              narrow_i,
    input  logic              hi_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned LANE_W = DATA_W / EBC_LANES;

    typedef logic [EBC_LANES-1:0][LANE_W-1:0] lanes_t;

    lanes_t rd_d, rd_q;
    logic [EBC_LANES-1:0]             cap_w;
    logic [EBC_LANES-1:0][LANE_W-1:0] src_w;
    logic data_ph_w;

    assign data_ph_w = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);

    always_comb begin
        ad_oe  = (phase_i == PH_ADDR) || (write_i && data_ph_w);
        ad_out = '0;
        if (phase_i == PH_ADDR) begin
            ad_out = DATA_W'(addr_i);
        end else if (write_i && data_ph_w) begin
            ad_out = wdata_i;
        end
    end

    for (genvar l = 0; l < EBC_LANES; l++) begin : g_lane
        // On the 8-bit bus every byte arrives on the low lane
        assign cap_w[l] = (phase_i == PH_STROBE) && !write_i &&
                          (!narrow_i || ((l == 0) ? !hi_i : hi_i));
        assign src_w[l] = narrow_i ? ad_in[LANE_W-1:0] : ad_in[l*LANE_W +: LANE_W];
    end

    always_comb begin
        rd_d = rd_q;
        if (load_i) begin
            rd_d = '0;
        end
        for (int l = 0; l < EBC_LANES; l++) begin
            if (cap_w[l]) begin
                rd_d[l] = src_w[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/ebc_top.sv
module ebc_top
    import ebc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_narrow,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_wr_plain,
    input  logic              cfg_latch_mode,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              lat_pin,
    output logic              rd_n,
    output logic              wr_n
);

    ebc_phase_e        phase_w;
    logic              load_w;
    logic              write_w;
    logic              narrow_w;
    logic              hi_w;
    logic              lowbe_w;
    logic [ADDR_W-1:0] addr_w;
    logic [DATA_W-1:0] wdata_w;

    ebc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_narrow   (req_narrow),
        .req_be       (req_be),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .load_o       (load_w),
        .done_o       (rsp_done),
        .phase_o      (phase_w),
        .beat_write_o (write_w),
        .beat_narrow_o(narrow_w),
        .beat_hi_o    (hi_w),
        .beat_lowbe_o (lowbe_w),
        .beat_addr_o  (addr_w),
        .beat_wdata_o (wdata_w)
    );

    ebc_strobe strobe_i (
        .phase_i       (phase_w),
        .write_i       (write_w),
        .narrow_i      (narrow_w),
        .lowbe_i       (lowbe_w),
        .cfg_wr_plain  (cfg_wr_plain),
        .cfg_latch_mode(cfg_latch_mode),
        .lat_pin       (lat_pin),
        .rd_n          (rd_n),
        .wr_n          (wr_n)
    );

    ebc_addata #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) addata_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .phase_i (phase_w),
        .write_i (write_w),
        .narrow_i(narrow_w),
        .hi_i    (hi_w),
        .addr_i  (addr_w),
        .wdata_i (wdata_w),
        .ad_in   (ad_in),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .rdata_o (rsp_rdata)
    );

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_latch_mode,
    input logic req_ready,
    input logic rsp_done,
    input logic ad_oe,
    input logic lat_pin,
    input logic rd_n,
    input logic wr_n
);

    // R13
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (wr_n && ad_oe));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R12
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R3
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_latch_mode && lat_pin) |=> !lat_pin);

    // R4
    adv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_latch_mode && rsp_done) |-> lat_pin);

endmodule

bind ebc_top ebc_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_latch_mode(cfg_latch_mode),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .ad_oe         (ad_oe),
    .lat_pin       (lat_pin),
    .rd_n          (rd_n),
    .wr_n          (wr_n)
);

// File: tb/ebc_top_tb.sv
module ebc_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] RD_KEY = 16'h5AA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_narrow = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_wr_plain = 1'b1;
    logic        cfg_latch_mode = 1'b0;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic        lat_pin;
    logic        rd_n;
    logic        wr_n;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebc_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_narrow(req_narrow), .req_be(req_be), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_wr_plain(cfg_wr_plain),
        .cfg_latch_mode(cfg_latch_mode), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .lat_pin(lat_pin), .rd_n(rd_n),
        .wr_n(wr_n)
    );

    // Memory model: latches the address seen in the address state
    logic [15:0] mdl_addr = '0;
    logic        prev_lat = 1'b1;
    assign ad_in = mdl_addr ^ RD_KEY;

    always @(posedge clk) begin
        #1;
        if (cfg_latch_mode ? (!lat_pin && prev_lat) : lat_pin) mdl_addr <= ad_out;
        prev_lat <= lat_pin;
    end

    typedef struct {
        logic        oe;
        logic [15:0] out;
        logic        lat;
        logic        rd;
        logic        wr;
        logic        done;
        logic        chk_rd;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check1(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_beat(input logic [15:0] a, input logic w, input logic [15:0] d,
                             input logic wen, input logic last, input logic [15:0] rexp,
                             input string tag);
        exp_t e;
        // address state (R2)
        e.oe = 1'b1; e.out = a; e.lat = cfg_latch_mode ? 1'b0 : 1'b1;
        e.rd = 1'b1; e.wr = 1'b1; e.done = 1'b0; e.chk_rd = 1'b0; e.rdata = '0; e.tag = tag;
        sb_q.push_back(e);
        // setup state
        e.oe = w; e.out = d; e.lat = 1'b0;
        sb_q.push_back(e);
        // strobe state
        e.rd = w; e.wr = !(w && wen);
        sb_q.push_back(e);
        // hold state
        e.rd = 1'b1; e.wr = 1'b1; e.lat = cfg_latch_mode ? 1'b1 : 1'b0;
        e.done = last; e.chk_rd = last && !w; e.rdata = rexp;
        sb_q.push_back(e);
    endtask

    // Driver: called at a falling edge; presents one request and queues its cycles
    task automatic issue(input logic w, input logic nar, input logic [1:0] be,
                         input logic [15:0] a, input logic [15:0] d, input string tag);
        logic        wen;
        logic [15:0] lo;
        logic [15:0] hi;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_narrow = nar; req_be = be;
        req_addr = a; req_wdata = d;
        wen = cfg_wr_plain || nar || be[0];
        lo = a ^ RD_KEY;
        hi = (a + 16'd1) ^ RD_KEY;
        if (!nar) begin
            push_beat(a, w, d, wen, 1'b1, lo, tag);
        end else if (be == 2'b11) begin
            push_beat(a, w, {2{d[7:0]}}, wen, 1'b0, '0, tag);
            push_beat(a + 16'd1, w, {2{d[15:8]}}, wen, 1'b1, {hi[7:0], lo[7:0]}, tag);
        end else if (be == 2'b10) begin
            push_beat(a + 16'd1, w, {2{d[15:8]}}, wen, 1'b1, {hi[7:0], 8'h00}, tag);
        end else begin
            push_beat(a, w, {2{d[7:0]}}, wen, 1'b1, {8'h00, lo[7:0]}, tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares every cycle against the scoreboard, idle pins when empty.
    // rd_n and wr_n are compared each cycle, which covers R13 as well.
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !finished) begin
            exp_t e;
            logic ok;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
            end else begin
                e.oe = 1'b0; e.out = '0; e.lat = cfg_latch_mode; e.rd = 1'b1; e.wr = 1'b1;
                e.done = 1'b0; e.chk_rd = 1'b0; e.rdata = '0; e.tag = "R1 idle";
            end
            ok = (ad_oe === e.oe) && (!e.oe || ad_out === e.out) && (lat_pin === e.lat) &&
                 (rd_n === e.rd) && (wr_n === e.wr) && (rsp_done === e.done) &&
                 (!e.chk_rd || rsp_rdata === e.rdata);
            n_checks++;
            if (!ok) begin
                n_errors++;
                $display("FAIL %s oe/out/lat/rd/wr/done/rdata actual=%b/%h/%b/%b/%b/%b/%h expected=%b/%h/%b/%b/%b/%b/%h",
                         e.tag, ad_oe, ad_out, lat_pin, rd_n, wr_n, rsp_done, rsp_rdata,
                         e.oe, e.out, e.lat, e.rd, e.wr, e.done, e.rdata);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++;
        $display("FAIL watchdog R12 actual=hung expected=complete");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check1("R1 req_ready", 16'(req_ready), 16'h1);
        check1("R1 ad_oe", 16'(ad_oe), 16'h0);
        check1("R1 rd_n", 16'(rd_n), 16'h1);
        check1("R1 wr_n", 16'(wr_n), 16'h1);
        check1("R1 lat_pin", 16'(lat_pin), 16'h0);
        check1("R1 rsp_done", 16'(rsp_done), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: wide read, latch pulse style
        issue(1'b0, 1'b0, 2'b11, 16'h1234, 16'h0000, "R2 R3 R5");
        wait_idle();
        // R6 R7: plain strobe, word and upper-byte writes
        issue(1'b1, 1'b0, 2'b11, 16'h2468, 16'hBEEF, "R6 R7");
        issue(1'b1, 1'b0, 2'b10, 16'h2000, 16'hCAFE, "R7");
        wait_idle();
        // R8: low-byte style on the wide bus
        cfg_wr_plain = 1'b0;
        issue(1'b1, 1'b0, 2'b11, 16'h2100, 16'h1111, "R8");
        issue(1'b1, 1'b0, 2'b10, 16'h2200, 16'h2222, "R8 upper-only");
        issue(1'b1, 1'b0, 2'b01, 16'h2300, 16'h3333, "R8 lower-only");
        wait_idle();
        // R9 R11: single byte cycles on the 8-bit bus
        issue(1'b1, 1'b1, 2'b10, 16'h3000, 16'hA55A, "R9 R11");
        issue(1'b1, 1'b1, 2'b01, 16'h3010, 16'h7E81, "R9 R11");
        issue(1'b0, 1'b1, 2'b10, 16'h3020, 16'h0000, "R11 read");
        wait_idle();
        // R4 R10: address-valid style, split word accesses
        cfg_latch_mode = 1'b1;
        @(negedge clk);
        issue(1'b0, 1'b1, 2'b11, 16'h4000, 16'h0000, "R4 R10");
        issue(1'b1, 1'b1, 2'b11, 16'h5000, 16'h1357, "R4 R10");
        wait_idle();
        // R12: back-to-back in both latch styles
        issue(1'b1, 1'b0, 2'b11, 16'h6000, 16'h9999, "R12");
        issue(1'b0, 1'b0, 2'b11, 16'h6100, 16'h0000, "R12");
        issue(1'b0, 1'b1, 2'b11, 16'h6200, 16'h0000, "R12");
        wait_idle();
        cfg_latch_mode = 1'b0;
        @(negedge clk);
        issue(1'b0, 1'b0, 2'b11, 16'h7000, 16'h0000, "R12 R3");
        issue(1'b1, 1'b1, 2'b11, 16'h7100, 16'h4242, "R12 R3");
        issue(1'b0, 1'b1, 2'b01, 16'h7200, 16'h0000, "R12 R11");
        wait_idle();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule